// File: doc/BRIEF.md
# Descriptor Ring DMA Walker

This block is the control engine of a storage-card host's internal DMA. Software builds a ring or chain of four-word descriptors in system memory, programs the address of the first one, and issues a poll demand. The walker then fetches each descriptor and checks whether the DMA owns it. For an owned descriptor it moves the described buffer between memory and the card data FIFO, trading a request/grant handshake with the FIFO before each burst. It then hands the descriptor back by rewriting its first word with the ownership bit cleared, and moves on to the next one.

Descriptor layout: word 0 carries ownership in bit 31, an end-of-ring flag in bit 5 and a chained flag in bit 4. Word 1 bits [15:0] give the buffer length in 32-bit words. Word 2 is the buffer address and word 3 the next-descriptor address. A descriptor without the chained flag is followed by the next one after a programmable gap of skip words. A fixed-burst option limits data bursts to sized increments. The current walker state is readable at any time, and a self-clearing soft reset returns the whole block to its power-on condition. The reset input is asserted asynchronously and released synchronously to the clock.

The register port has four selects, with single-cycle writes and combinational reads. Select 0 is control: bit 0 soft reset, bit 1 fixed burst, bit 2 direction (1 = card data written into memory), bits [7:3] skip length in words. Select 1 is the base address, select 2 the status (state code in bits [3:0]), and a write to select 3 is a poll demand.

Top module: `desc_dma_ctrl`

## Requirements
- R1: After reset the state code is 0 (idle), control reads 0x20 (skip 4, fixed burst off, direction 0) and the base reads 0. The state codes are: 0 idle, 1 suspend, 2 descriptor fetch, 3 descriptor check, 4 read-request wait, 5 write-request wait, 6 data read, 7 data write, 8 descriptor close. The status select returns the current code.
- R2: The base address register stores a 32-bit value whose bits [1:0] read back as zero whatever was written.
- R3: A poll demand in idle starts a fetch at the base address: four single-beat reads (burst code 0) at offsets 0, 4, 8 and 12. Every memory request holds its address until it is acknowledged.
- R4: A fetched descriptor whose bit 31 is clear sends the walker to suspend (code 1), where it issues no memory requests until a poll demand makes it fetch the same descriptor again.
- R5: An owned descriptor with direction 0 enters code 4, and with direction 1 enters code 5. In either state the walker raises fifo_req, and it starts data beats (code 6 or 7) only after fifo_gnt. Beat addresses start at word 2 and step by 4.
- R6: With fixed burst on, each burst is chosen from the remaining length: 8 or more words gives INCR8 (code 3) of 8 beats, 4 to 7 gives INCR4 (code 2) of 4 beats, and fewer than 4 gives SINGLE (code 0) of 1 beat.
- R7: With fixed burst off, a remaining length above 1 gives one INCR burst (code 1) covering all remaining words, and a length of 1 gives SINGLE.
- R8: Closing a descriptor writes word 0 back to the descriptor address as a single beat, with bit 31 cleared and all other bits kept.
- R9: The next descriptor address is word 3 with bits [1:0] forced to zero when the chained flag is set. Otherwise it is the current address plus 16 plus four times the skip length.
- R10: When the end-of-ring flag is set, the next descriptor address is the base address.
- R11: Writing 1 to control bit 0 makes that bit read 1 for exactly one cycle. The following cycle the state is idle and every register holds its reset value.
- R12: In data read, each acknowledged memory word is presented on fifo_wdata with fifo_push high. In data write, mem_wdata carries fifo_rdata and fifo_pop is high on the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_burst | output | 2 | Burst type: 0 SINGLE, 1 INCR, 2 INCR4, 3 INCR8 |
| mem_ack | input | 1 | Beat accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| fifo_req | output | 1 | Request for a FIFO burst slot |
| fifo_gnt | input | 1 | Grant of the FIFO burst slot |
| fifo_push | output | 1 | Word on fifo_wdata is valid |
| fifo_wdata | output | 32 | Data toward the FIFO |
| fifo_pop | output | 1 | Word on fifo_rdata consumed |
| fifo_rdata | input | 32 | Data from the FIFO |
| state_code | output | 4 | Current walker state code |

## Verification
The assertions assume that mem_ack comes only while mem_req is high and that fifo_gnt comes only while fifo_req is high. They also assume that the fixed-burst bit, the direction and the skip length are rewritten only while the walker is idle or suspended. The bench's memory and FIFO responders answer only pending requests. They acknowledge each request on its second falling edge so that a held request is observed, and they grant for a single cycle. Control and base writes are issued only with the walker in idle or suspend.

// File: rtl/dmaw_pkg.sv
`timescale 1ns/1ps
package dmaw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_SUSP  = 4'd1,
    ST_DRD   = 4'd2,
    ST_DCHK  = 4'd3,
    ST_RWAIT = 4'd4,
    ST_WWAIT = 4'd5,
    ST_DATRD = 4'd6,
    ST_DATWR = 4'd7,
    ST_CLOSE = 4'd8
  } walk_st_e;

  typedef enum logic [1:0] {
    BT_SINGLE = 2'd0,
    BT_INCR   = 2'd1,
    BT_INCR4  = 2'd2,
    BT_INCR8  = 2'd3
  } burst_e;

  localparam int OWN_BIT = 31;
  localparam int EOR_BIT = 5;
  localparam int CHN_BIT = 4;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_POLL = 2'd3;
endpackage

// File: rtl/dmaw_regs.sv
`timescale 1ns/1ps
module dmaw_regs
  import dmaw_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SKIP_W   = 5,
  parameter int SKIP_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [3:0]        state_code,
  output logic              srst,
  output logic              poll,
  output logic              fixed_burst,
  output logic              dir_to_mem,
  output logic [SKIP_W-1:0] skip_len,
  output logic [AW-1:0]     base_addr
);
  localparam int CTRL_W = 3 + SKIP_W;

  logic              srst_q, fixed_q, dir_q;
  logic [SKIP_W-1:0] skip_q;
  logic [AW-1:2]     base_q;
  logic              ctrl_wr, base_wr;

  assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL) && !srst_q;
  assign base_wr = reg_wr && (reg_sel == SEL_BASE) && !srst_q;
  assign poll    = reg_wr && (reg_sel == SEL_POLL) && !srst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= 1'b0;
      fixed_q <= 1'b0;
      dir_q   <= 1'b0;
      skip_q  <= SKIP_W'(SKIP_RST);
      base_q  <= '0;
    end else if (srst_q) begin
      srst_q  <= 1'b0;
      fixed_q <= 1'b0;
      dir_q   <= 1'b0;
      skip_q  <= SKIP_W'(SKIP_RST);
      base_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        if (reg_wdata[0]) begin
          srst_q <= 1'b1;
        end else begin
          fixed_q <= reg_wdata[1];
          dir_q   <= reg_wdata[2];
          skip_q  <= reg_wdata[3 +: SKIP_W];
        end
      end
      if (base_wr) base_q <= reg_wdata[AW-1:2];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: reg_rdata[CTRL_W-1:0] = {skip_q, dir_q, fixed_q, srst_q};
      SEL_BASE: reg_rdata[AW-1:0]     = {base_q, 2'b00};
      SEL_STAT: reg_rdata[3:0]        = state_code;
      default:  reg_rdata             = '0;
    endcase
  end

  assign srst        = srst_q;
  assign fixed_burst = fixed_q;
  assign dir_to_mem  = dir_q;
  assign skip_len    = skip_q;
  assign base_addr   = {base_q, 2'b00};

  // R11: the soft reset strobe never lasts beyond one cycle
  a_r11_srst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);
endmodule

// File: rtl/dmaw_burst.sv
`timescale 1ns/1ps
module dmaw_burst
  import dmaw_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             fixed_burst,
  input  logic [LEN_W-1:0] remain,
  output burst_e           code,
  output logic [LEN_W-1:0] beats
);
  always_comb begin
    if (fixed_burst) begin
      if (remain >= LEN_W'(8)) begin
        code  = BT_INCR8;
        beats = LEN_W'(8);
      end else if (remain >= LEN_W'(4)) begin
        code  = BT_INCR4;
        beats = LEN_W'(4);
      end else begin
        code  = BT_SINGLE;
        beats = LEN_W'(1);
      end
    end else if (remain > LEN_W'(1)) begin
      code  = BT_INCR;
      beats = remain;
    end else begin
      code  = BT_SINGLE;
      beats = LEN_W'(1);
    end
  end
endmodule

// File: rtl/dmaw_walker.sv
`timescale 1ns/1ps
module dmaw_walker
  import dmaw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LEN_W  = 16,
  parameter int SKIP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              poll,
  input  logic              fixed_burst,
  input  logic              dir_to_mem,
  input  logic [SKIP_W-1:0] skip_len,
  input  logic [AW-1:0]     base_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [1:0]        mem_burst,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              fifo_req,
  input  logic              fifo_gnt,
  output logic              fifo_push,
  output logic [31:0]       fifo_wdata,
  output logic              fifo_pop,
  input  logic [31:0]       fifo_rdata,
  output logic [3:0]        state_code
);
  localparam int DESC_BYTES = 16;

  walk_st_e         st_q, st_d;
  logic [1:0]       idx_q;
  logic [AW-1:0]    cur_q, ptr_q, next_addr;
  logic [AW-1:2]    nxt_q;
  logic [31:0]      w0_q;
  logic [LEN_W-1:0] rem_q, chunk_q, bt_len;
  burst_e           burst_q, bt_code;
  logic             wait_st, dat_st;

  dmaw_burst #(.LEN_W(LEN_W)) u_burst (
    .fixed_burst(fixed_burst),
    .remain     (rem_q),
    .code       (bt_code),
    .beats      (bt_len)
  );

  assign wait_st = (st_q == ST_RWAIT) || (st_q == ST_WWAIT);
  assign dat_st  = (st_q == ST_DATRD) || (st_q == ST_DATWR);

  always_comb begin
    if (w0_q[EOR_BIT])      next_addr = base_addr;
    else if (w0_q[CHN_BIT]) next_addr = {nxt_q, 2'b00};
    else next_addr = cur_q + AW'(DESC_BYTES) + (AW'(skip_len) << 2);
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (poll) st_d = ST_DRD;
      ST_SUSP:  if (poll) st_d = ST_DRD;
      ST_DRD:   if (mem_ack && idx_q == 2'd3) st_d = ST_DCHK;
      ST_DCHK: begin
        if (!w0_q[OWN_BIT])         st_d = ST_SUSP;
        else if (rem_q == '0)       st_d = ST_CLOSE;
        else if (dir_to_mem)        st_d = ST_WWAIT;
        else                        st_d = ST_RWAIT;
      end
      ST_RWAIT: if (fifo_gnt) st_d = ST_DATRD;
      ST_WWAIT: if (fifo_gnt) st_d = ST_DATWR;
      ST_DATRD, ST_DATWR: begin
        if (mem_ack && chunk_q == LEN_W'(1)) begin
          if (rem_q == LEN_W'(1))    st_d = ST_CLOSE;
          else if (st_q == ST_DATRD) st_d = ST_RWAIT;
          else                       st_d = ST_WWAIT;
        end
      end
      ST_CLOSE: if (mem_ack) st_d = ST_DRD;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; cur_q <= '0; ptr_q <= '0; nxt_q <= '0;
      w0_q <= '0; rem_q <= '0; chunk_q <= '0; burst_q <= BT_SINGLE;
    end else if (srst) begin
      st_q <= ST_IDLE; idx_q <= '0; cur_q <= '0; ptr_q <= '0; nxt_q <= '0;
      w0_q <= '0; rem_q <= '0; chunk_q <= '0; burst_q <= BT_SINGLE;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && poll) cur_q <= base_addr;
      if ((st_q == ST_IDLE || st_q == ST_SUSP) && poll) idx_q <= '0;
      if (st_q == ST_DRD && mem_ack) begin
        idx_q <= idx_q + 2'd1;
        case (idx_q)
          2'd0:    w0_q  <= mem_rdata;
          2'd1:    rem_q <= mem_rdata[LEN_W-1:0];
          2'd2:    ptr_q <= mem_rdata[AW-1:0];
          default: nxt_q <= mem_rdata[AW-1:2];
        endcase
      end
      if (wait_st && fifo_gnt) begin
        burst_q <= bt_code;
        chunk_q <= bt_len;
      end
      if (dat_st && mem_ack) begin
        ptr_q   <= ptr_q + AW'(4);
        rem_q   <= rem_q - LEN_W'(1);
        chunk_q <= chunk_q - LEN_W'(1);
      end
      if (st_q == ST_CLOSE && mem_ack) begin
        cur_q <= next_addr;
        idx_q <= '0;
      end
    end
  end

  always_comb begin
    mem_req   = (st_q == ST_DRD) || dat_st || (st_q == ST_CLOSE);
    mem_we    = (st_q == ST_DATWR) || (st_q == ST_CLOSE);
    mem_burst = dat_st ? burst_q : BT_SINGLE;
    case (st_q)
      ST_DRD:             mem_addr = cur_q + AW'({idx_q, 2'b00});
      ST_DATRD, ST_DATWR: mem_addr = ptr_q;
      ST_CLOSE:           mem_addr = cur_q;
      default:            mem_addr = '0;
    endcase
    if (st_q == ST_CLOSE)      mem_wdata = w0_q & ~(32'd1 << OWN_BIT);
    else if (st_q == ST_DATWR) mem_wdata = fifo_rdata;
    else                       mem_wdata = '0;
  end

  assign fifo_req   = wait_st;
  assign fifo_push  = (st_q == ST_DATRD) && mem_ack;
  assign fifo_wdata = mem_rdata;
  assign fifo_pop   = (st_q == ST_DATWR) && mem_ack;
  assign state_code = st_q;

  // R3: a pending request keeps its address until acknowledged
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R4: a descriptor not owned sends the walker to suspend
  a_r4_free_suspends: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (st_q == ST_DCHK && !w0_q[OWN_BIT]) |=> (st_q == ST_SUSP));

  // R5: data reads begin only out of the read wait with a grant
  a_r5_grant_first: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (st_q == ST_DATRD && $past(st_q) != ST_DATRD) |->
      ($past(st_q) == ST_RWAIT && $past(fifo_gnt)));

  // R6: with fixed bursts on, no undefined-length burst is issued
  a_r6_fixed_burst: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (mem_req && fixed_burst && dat_st) |-> (mem_burst != BT_INCR));
endmodule

// File: rtl/desc_dma_ctrl.sv
`timescale 1ns/1ps
module desc_dma_ctrl
  import dmaw_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LEN_W    = 16,
  parameter int SKIP_W   = 5,
  parameter int SKIP_RST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [1:0]  mem_burst,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        fifo_req,
  input  logic        fifo_gnt,
  output logic        fifo_push,
  output logic [31:0] fifo_wdata,
  output logic        fifo_pop,
  input  logic [31:0] fifo_rdata,
  output logic [3:0]  state_code
);
  logic              srst, poll, fixed_burst, dir_to_mem;
  logic [SKIP_W-1:0] skip_len;
  logic [AW-1:0]     base_addr;

  dmaw_regs #(.AW(AW), .SKIP_W(SKIP_W), .SKIP_RST(SKIP_RST)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .state_code (state_code),
    .srst       (srst),
    .poll       (poll),
    .fixed_burst(fixed_burst),
    .dir_to_mem (dir_to_mem),
    .skip_len   (skip_len),
    .base_addr  (base_addr)
  );

  dmaw_walker #(.AW(AW), .LEN_W(LEN_W), .SKIP_W(SKIP_W)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst       (srst),
    .poll       (poll),
    .fixed_burst(fixed_burst),
    .dir_to_mem (dir_to_mem),
    .skip_len   (skip_len),
    .base_addr  (base_addr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_burst  (mem_burst),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .fifo_req   (fifo_req),
    .fifo_gnt   (fifo_gnt),
    .fifo_push  (fifo_push),
    .fifo_wdata (fifo_wdata),
    .fifo_pop   (fifo_pop),
    .fifo_rdata (fifo_rdata),
    .state_code (state_code)
  );
endmodule

// File: tb/desc_dma_ctrl_bench.sv
`timescale 1ns/1ps
module desc_dma_ctrl_bench;
  logic        clk, rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_burst;
  logic        fifo_req, fifo_gnt, fifo_push, fifo_pop;
  logic [31:0] fifo_wdata, fifo_rdata;
  logic [3:0]  state_code;

  desc_dma_ctrl u_desc_dma_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_burst(mem_burst), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .fifo_req(fifo_req), .fifo_gnt(fifo_gnt), .fifo_push(fifo_push),
    .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
    .state_code(state_code)
  );

  typedef struct {
    logic [31:0] addr;
    logic        we;
    logic [1:0]  bt;
    logic [31:0] data;
    string       tag;
  } txn_t;

  typedef struct {
    logic [3:0] code;
    string      tag;
  } stx_t;

  txn_t        exp_txn[$];
  stx_t        exp_st[$];
  logic [31:0] mem [0:1023];
  int          checks, errors;
  int          pat, epat, lat;
  logic [3:0]  last_st;
  bit          done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_st(input logic [3:0] c, input string tag);
    stx_t s;
    s.code = c; s.tag = tag;
    exp_st.push_back(s);
  endtask

  task automatic push_txn(input logic [31:0] a, input logic w, input logic [1:0] b,
                          input logic [31:0] d, input string tag);
    txn_t t;
    t.addr = a; t.we = w; t.bt = b; t.data = d; t.tag = tag;
    exp_txn.push_back(t);
  endtask

  // descriptor fetch: four single reads, then the check state
  task automatic exp_desc(input logic [31:0] a, input string tag);
    push_st(4'd2, tag);
    for (int i = 0; i < 4; i++) push_txn(a + 32'(4 * i), 1'b0, 2'd0, 32'd0, tag);
    push_st(4'd3, "R1 check state");
  endtask

  // data phase: burst choice per R6 / R7
  task automatic exp_data(input logic [31:0] buf_a, input int len, input bit fx,
                          input bit wr);
    int rem, n;
    logic [1:0] bt;
    logic [31:0] p;
    rem = len; p = buf_a;
    while (rem > 0) begin
      if (fx) begin
        if (rem >= 8)      begin bt = 2'd3; n = 8; end
        else if (rem >= 4) begin bt = 2'd2; n = 4; end
        else               begin bt = 2'd0; n = 1; end
      end else if (rem > 1) begin bt = 2'd1; n = rem; end
      else begin bt = 2'd0; n = 1; end
      push_st(wr ? 4'd5 : 4'd4, "R5 wait state");
      push_st(wr ? 4'd7 : 4'd6, "R5 data state");
      for (int i = 0; i < n; i++) begin
        push_txn(p, wr, bt, wr ? (32'hD000_0000 + 32'(epat)) : 32'd0,
                 fx ? "R6 fixed burst beat" : "R7 free burst beat");
        if (wr) epat++;
        p = p + 32'd4;
      end
      rem = rem - n;
    end
  endtask

  task automatic exp_close(input logic [31:0] a, input logic [31:0] w0);
    push_st(4'd8, "R8 close state");
    push_txn(a, 1'b1, 2'd0, w0 & 32'h7FFF_FFFF, "R8 write-back");
  endtask

  task automatic set_desc(input logic [31:0] a, input logic [31:0] w0,
                          input logic [31:0] w1, input logic [31:0] w2,
                          input logic [31:0] w3);
    mem[a[11:2]]     = w0;
    mem[a[11:2] + 1] = w1;
    mem[a[11:2] + 2] = w2;
    mem[a[11:2] + 3] = w3;
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_suspend();
    while (!(state_code == 4'd1 && exp_txn.size() == 0 && exp_st.size() == 0))
      @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // memory responder and transaction monitor
  initial begin
    mem_ack = 1'b0; mem_rdata = '0; lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req && rst_n) begin
        if (lat == 0) begin
          lat = 1;
        end else begin
          txn_t t;
          lat = 0;
          if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[11:2]] ^ 32'h0;
          mem_ack = 1'b1;
          if (exp_txn.size() == 0) begin
            check(1'b0, "R3 unexpected memory request", mem_addr, 32'hFFFF_FFFF);
          end else begin
            t = exp_txn.pop_front();
            check(mem_addr == t.addr, {t.tag, " address"}, mem_addr, t.addr);
            check(mem_we == t.we, {t.tag, " direction"}, 32'(mem_we), 32'(t.we));
            check(mem_burst == t.bt, {t.tag, " burst type"}, 32'(mem_burst), 32'(t.bt));
            if (t.we) check(mem_wdata == t.data, {t.tag, " write data"}, mem_wdata, t.data);
          end
          #1;
          if (state_code == 4'd6) begin
            check(fifo_push == 1'b1, "R12 push on read beat", 32'(fifo_push), 32'd1);
            check(fifo_wdata == mem_rdata, "R12 pushed word", fifo_wdata, mem_rdata);
          end
          if (state_code == 4'd7) begin
            check(fifo_pop == 1'b1, "R12 pop on write beat", 32'(fifo_pop), 32'd1);
            pat++;
          end
        end
      end
    end
  end

  assign fifo_rdata = 32'hD000_0000 + 32'(pat);

  // FIFO grant model: one-cycle grant per request
  initial begin
    fifo_gnt = 1'b0;
    forever begin
      @(negedge clk);
      if (fifo_gnt)                fifo_gnt = 1'b0;
      else if (fifo_req && rst_n)  fifo_gnt = 1'b1;
    end
  end

  // state-code monitor
  initial begin
    last_st = 4'd0;
    forever begin
      @(negedge clk);
      if (rst_n && state_code != last_st) begin
        if (exp_st.size() == 0) begin
          check(1'b0, "R1 unexpected state change", 32'(state_code), 32'(last_st));
        end else begin
          stx_t s;
          s = exp_st.pop_front();
          check(state_code == s.code, s.tag, 32'(state_code), 32'(s.code));
        end
        last_st = state_code;
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired, walker hung");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    checks = 0; errors = 0; pat = 0; epat = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h1000_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd0, rd); check(rd == 32'h20, "R1 control reset value", rd, 32'h20);
    reg_read(2'd1, rd); check(rd == 32'h0, "R1 base reset value", rd, 32'h0);
    reg_read(2'd2, rd); check(rd == 32'h0, "R1 status idle", rd, 32'h0);
    check(mem_req == 1'b0 && fifo_req == 1'b0, "R1 no requests after reset",
          {30'd0, mem_req, fifo_req}, 32'd0);

    // R2 base alignment
    reg_write(2'd1, 32'h0000_0103);
    reg_read(2'd1, rd); check(rd == 32'h100, "R2 base low bits read zero", rd, 32'h100);

    // scenario 1: fixed bursts, memory to FIFO, three-descriptor ring
    reg_write(2'd0, 32'h12);
    reg_read(2'd0, rd); check(rd == 32'h12, "R1 control readback", rd, 32'h12);
    set_desc(32'h100, 32'h8000_0100, 32'd10, 32'h400, 32'h0);
    set_desc(32'h118, 32'h8000_0210, 32'd5,  32'h500, 32'h203);
    set_desc(32'h200, 32'h8000_0320, 32'd3,  32'h600, 32'h0);
    exp_desc(32'h100, "R3 fetch from base");
    exp_data(32'h400, 10, 1'b1, 1'b0);
    exp_close(32'h100, 32'h8000_0100);
    exp_desc(32'h118, "R9 dual-buffer skip fetch");
    exp_data(32'h500, 5, 1'b1, 1'b0);
    exp_close(32'h118, 32'h8000_0210);
    exp_desc(32'h200, "R9 chained fetch");
    exp_data(32'h600, 3, 1'b1, 1'b0);
    exp_close(32'h200, 32'h8000_0320);
    exp_desc(32'h100, "R10 end-of-ring wrap");
    push_st(4'd1, "R4 suspend on cleared owner");
    reg_write(2'd3, 32'h0);
    wait_suspend();
    check(mem_req == 1'b0, "R4 no requests in suspend", 32'(mem_req), 32'd0);
    reg_read(2'd2, rd); check(rd == 32'h1, "R1 status suspend", rd, 32'h1);
    check(mem[32'h100 >> 2] == 32'h0000_0100, "R8 ring owner cleared",
          mem[32'h100 >> 2], 32'h0000_0100);

    // scenario 2: free bursts, FIFO to memory, resume from suspend
    reg_write(2'd0, 32'h14);
    set_desc(32'h100, 32'h8000_0100, 32'd6, 32'h400, 32'h0);
    set_desc(32'h118, 32'h8000_0210, 32'd1, 32'h500, 32'h200);
    set_desc(32'h200, 32'h0000_0320, 32'd3, 32'h600, 32'h0);
    exp_desc(32'h100, "R4 poll refetches same descriptor");
    exp_data(32'h400, 6, 1'b0, 1'b1);
    exp_close(32'h100, 32'h8000_0100);
    exp_desc(32'h118, "R9 dual-buffer skip fetch");
    exp_data(32'h500, 1, 1'b0, 1'b1);
    exp_close(32'h118, 32'h8000_0210);
    exp_desc(32'h200, "R9 chained fetch");
    push_st(4'd1, "R4 suspend on cleared owner");
    reg_write(2'd3, 32'h0);
    wait_suspend();
    check(mem[32'h414 >> 2] == 32'hD000_0005, "R12 last FIFO word stored",
          mem[32'h414 >> 2], 32'hD000_0005);

    // scenario 3: soft reset, then default skip
    push_st(4'd0, "R11 idle after soft reset");
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    reg_read(2'd0, rd); check(rd[0] == 1'b1, "R11 soft reset bit visible", rd, 32'h1);
    @(negedge clk);
    reg_read(2'd0, rd); check(rd == 32'h20, "R11 control back to default", rd, 32'h20);
    reg_read(2'd1, rd); check(rd == 32'h0, "R11 base cleared", rd, 32'h0);
    reg_read(2'd2, rd); check(rd == 32'h0, "R11 walker idle", rd, 32'h0);
    reg_write(2'd1, 32'h300);
    set_desc(32'h300, 32'h8000_0400, 32'd1, 32'h680, 32'h0);
    set_desc(32'h320, 32'h0000_0500, 32'd1, 32'h6C0, 32'h0);
    exp_desc(32'h300, "R3 fetch from new base");
    exp_data(32'h680, 1, 1'b0, 1'b0);
    exp_close(32'h300, 32'h8000_0400);
    exp_desc(32'h320, "R9 default skip of four words");
    push_st(4'd1, "R4 suspend on cleared owner");
    reg_write(2'd3, 32'h0);
    wait_suspend();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule